// File: doc/BRIEF.md
# Temperature Limit Event Comparator

This block watches a stream of signed temperature conversions and flags excursions against three thresholds held in writable limit registers: an upper limit, a lower limit and a critical trip point. Each sample is 12-bit two's complement with an LSB of 0.0625 °C. Samples typically arrive once per conversion period of roughly 100 ms. Each sample that arrives with its valid strobe is compared against all three limits. The three results are latched as status flags and held until the next sample.

The flags drive one shared alarm line. It is modelled as an open-drain pull-down enable, so a 1 on `alarm_pull_low` means the pin is pulled low and a 0 means it is released. The alarm asserts when the alarm enable is high and at least one flag is set. Under-limit and over-limit conditions therefore share the same pin. A host program sets the limits through a write port with a two-bit selector and reads the flags directly.

Top module: `temp_limit_event`

## Requirements
- R1: After reset all three flags read 0, `alarm_pull_low` is 0, and all three limits hold 0, so the first sample is compared against zero limits.
- R2: On a sample strobe, `flag_over_hi` becomes 1 exactly when the sample is strictly greater than the upper limit, and 0 otherwise.
- R3: On a sample strobe, `flag_under_lo` becomes 1 exactly when the sample is strictly less than the lower limit, and 0 otherwise.
- R4: On a sample strobe, `flag_crit` becomes 1 exactly when the sample is greater than or equal to the critical limit, and 0 otherwise.
- R5: Flags change only on the clock edge that sees `smp_valid` high. Between strobes they hold their values, including when limits are rewritten.
- R6: A write with `lim_wr` high loads `lim_wdata` into the limit chosen by `lim_sel`: 2'b00 is the upper limit, 2'b01 the lower limit and 2'b10 the critical limit. Selector 2'b11 changes no limit. A new limit applies to samples strobed on later edges.
- R7: While `alarm_en` is 1, `alarm_pull_low` is 1 whenever any flag is 1, and 0 when all flags are 0.
- R8: While `alarm_en` is 0, `alarm_pull_low` is 0 whatever the flags hold.
- R9: Samples and limits are compared as signed two's-complement numbers. For example, a sample of -1 (12'hFFF) is below a lower limit of 5, and a sample of 2047 is above an upper limit of -2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Strobe marking a new temperature sample |
| smp_temp | input | 12 | Signed sample, 0.0625 °C per LSB |
| lim_wr | input | 1 | Limit write enable |
| lim_sel | input | 2 | Limit selector: 00 upper, 01 lower, 10 critical, 11 none |
| lim_wdata | input | 12 | Signed limit value to write |
| alarm_en | input | 1 | Alarm output enable |
| alarm_pull_low | output | 1 | 1 pulls the open-drain alarm pin low |
| flag_over_hi | output | 1 | Sample above upper limit |
| flag_under_lo | output | 1 | Sample below lower limit |
| flag_crit | output | 1 | Sample at or above critical limit |

## Verification
The flags are registered, so they show the new result one clock edge after the sample strobe. A limit write made on one edge is first used by a sample strobed on a later edge. The alarm output is combinational from the flag registers and the enable, so it follows an enable change within the same cycle and follows a flag change on the same edge as the flag. The bench drives every input on the falling edge and samples the outputs on the next falling edge, half a cycle after the edge that registered the result. It compares them with values that its own functions compute from the limits it has written.

// File: rtl/tle_pkg.sv
package tle_pkg;

  // Limit selector codes; the order sets which register a write reaches.
  typedef enum logic [1:0] {
    SEL_UPPER = 2'b00,
    SEL_LOWER = 2'b01,
    SEL_CRIT  = 2'b10,
    SEL_NONE  = 2'b11
  } lim_sel_e;

  localparam int NUM_LIMITS = 3;

  typedef struct packed {
    logic crit;
    logic under_lo;
    logic over_hi;
  } flags_t;

  // Open-drain alarm: 1 means the pin is pulled low.
  function automatic logic alarm_level(input flags_t f, input logic en);
    return en & (f.crit | f.under_lo | f.over_hi);
  endfunction

endpackage

// File: rtl/tle_limit_bank.sv
module tle_limit_bank #(
  parameter int W     = 12,
  parameter int N_LIM = tle_pkg::NUM_LIMITS,
  parameter int SEL_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [SEL_W-1:0]    sel,
  input  logic [W-1:0]        wdata,
  output logic [W-1:0]        lim_q [N_LIM]
);

  for (genvar g = 0; g < N_LIM; g++) begin : g_lim
    logic hit;
    assign hit = wr && (sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lim_q[g] <= '0;
      else if (hit) lim_q[g] <= wdata;
    end
  end

endmodule

// File: rtl/tle_compare.sv
module tle_compare #(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [W-1:0]        smp_temp,
  input  logic [W-1:0]        lim_upper,
  input  logic [W-1:0]        lim_lower,
  input  logic [W-1:0]        lim_crit,
  output tle_pkg::flags_t     flags_q
);

  function automatic logic gt_signed(input logic [W-1:0] a, input logic [W-1:0] b);
    return $signed(a) > $signed(b);
  endfunction

  function automatic logic lt_signed(input logic [W-1:0] a, input logic [W-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  function automatic logic ge_signed(input logic [W-1:0] a, input logic [W-1:0] b);
    return $signed(a) >= $signed(b);
  endfunction

  tle_pkg::flags_t flags_d;

  always_comb begin
    flags_d.over_hi  = gt_signed(smp_temp, lim_upper);
    flags_d.under_lo = lt_signed(smp_temp, lim_lower);
    flags_d.crit     = ge_signed(smp_temp, lim_crit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags_q <= '0;
    else if (smp_valid) flags_q <= flags_d;
  end

endmodule

// File: rtl/tle_alarm_out.sv
module tle_alarm_out (
  input  tle_pkg::flags_t flags,
  input  logic            en,
  output logic            pull_low
);

  assign pull_low = tle_pkg::alarm_level(flags, en);

endmodule

// File: rtl/temp_limit_event.sv
module temp_limit_event #(
  parameter int TEMP_W = 12,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [TEMP_W-1:0] smp_temp,
  input  logic              lim_wr,
  input  logic [SEL_W-1:0]  lim_sel,
  input  logic [TEMP_W-1:0] lim_wdata,
  input  logic              alarm_en,
  output logic              alarm_pull_low,
  output logic              flag_over_hi,
  output logic              flag_under_lo,
  output logic              flag_crit
);

  localparam int N_LIM   = tle_pkg::NUM_LIMITS;
  localparam int IDX_UP  = int'(tle_pkg::SEL_UPPER);
  localparam int IDX_LO  = int'(tle_pkg::SEL_LOWER);
  localparam int IDX_CR  = int'(tle_pkg::SEL_CRIT);

  logic [TEMP_W-1:0] lim_q [N_LIM];
  logic [TEMP_W-1:0] lim_upper_w;
  logic [TEMP_W-1:0] lim_lower_w;
  logic [TEMP_W-1:0] lim_crit_w;
  tle_pkg::flags_t   flags_w;

  tle_limit_bank #(.W(TEMP_W), .N_LIM(N_LIM), .SEL_W(SEL_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (lim_wr),
    .sel   (lim_sel),
    .wdata (lim_wdata),
    .lim_q (lim_q)
  );

  assign lim_upper_w = lim_q[IDX_UP];
  assign lim_lower_w = lim_q[IDX_LO];
  assign lim_crit_w  = lim_q[IDX_CR];

  tle_compare #(.W(TEMP_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_temp  (smp_temp),
    .lim_upper (lim_upper_w),
    .lim_lower (lim_lower_w),
    .lim_crit  (lim_crit_w),
    .flags_q   (flags_w)
  );

  tle_alarm_out u_alarm (
    .flags    (flags_w),
    .en       (alarm_en),
    .pull_low (alarm_pull_low)
  );

  assign flag_over_hi  = flags_w.over_hi;
  assign flag_under_lo = flags_w.under_lo;
  assign flag_crit     = flags_w.crit;

endmodule

// File: rtl/tle_checker.sv
module tle_checker #(
  parameter int TEMP_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [TEMP_W-1:0] smp_temp,
  input logic [TEMP_W-1:0] lim_upper,
  input logic [TEMP_W-1:0] lim_lower,
  input logic [TEMP_W-1:0] lim_crit,
  input logic              alarm_en,
  input logic              alarm_pull_low,
  input logic              f_hi,
  input logic              f_lo,
  input logic              f_cr
);

  p_over_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (f_hi == ($signed($past(smp_temp)) > $signed($past(lim_upper)))));

  p_under_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (f_lo == ($signed($past(smp_temp)) < $signed($past(lim_lower)))));

  p_crit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (f_cr == ($signed($past(smp_temp)) >= $signed($past(lim_crit)))));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(f_hi) && $stable(f_lo) && $stable(f_cr)));

  p_alarm_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_en && (f_hi || f_lo || f_cr)) |-> alarm_pull_low);

  p_alarm_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_hi || f_lo || f_cr) |-> !alarm_pull_low);

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_en |-> !alarm_pull_low);

endmodule

bind temp_limit_event tle_checker #(.TEMP_W(TEMP_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .smp_valid      (smp_valid),
  .smp_temp       (smp_temp),
  .lim_upper      (lim_upper_w),
  .lim_lower      (lim_lower_w),
  .lim_crit       (lim_crit_w),
  .alarm_en       (alarm_en),
  .alarm_pull_low (alarm_pull_low),
  .f_hi           (flag_over_hi),
  .f_lo           (flag_under_lo),
  .f_cr           (flag_crit)
);

// File: tb/sim_temp_limit_event.sv
module sim_temp_limit_event;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_temp = '0;
  logic        lim_wr = 1'b0;
  logic [1:0]  lim_sel = '0;
  logic [11:0] lim_wdata = '0;
  logic        alarm_en = 1'b0;
  logic        alarm_pull_low, flag_over_hi, flag_under_lo, flag_crit;

  int checks = 0;
  int errors = 0;
  int m_hi = 0, m_lo = 0, m_cr = 0;   // bench copy of the limits
  int e_flags = 0;                    // {crit, under, over} expected

  always #5 clk = ~clk;

  temp_limit_event u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
    .lim_wr(lim_wr), .lim_sel(lim_sel), .lim_wdata(lim_wdata),
    .alarm_en(alarm_en), .alarm_pull_low(alarm_pull_low),
    .flag_over_hi(flag_over_hi), .flag_under_lo(flag_under_lo), .flag_crit(flag_crit)
  );

  function automatic int to_int(input logic [11:0] v);
    return int'($signed(v));
  endfunction

  function automatic int calc_flags(input int t, input int hi, input int lo, input int cr);
    int r = 0;
    if (t > hi)  r |= 1;
    if (t < lo)  r |= 2;
    if (t >= cr) r |= 4;
    return r;
  endfunction

  function automatic int calc_pin(input int f, input logic en);
    return (en && f != 0) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dut_flags();
    return {29'd0, flag_crit, flag_under_lo, flag_over_hi};
  endfunction

  task automatic check_outputs(input string req);
    chk(req, dut_flags(), e_flags);
    chk(req, int'(alarm_pull_low), calc_pin(e_flags, alarm_en));
  endtask

  task automatic write_lim(input logic [1:0] sel, input int val);
    @(negedge clk);
    lim_wr = 1'b1; lim_sel = sel; lim_wdata = 12'(val);
    @(negedge clk);
    lim_wr = 1'b0;
    case (sel)
      2'b00: m_hi = to_int(12'(val));
      2'b01: m_lo = to_int(12'(val));
      2'b10: m_cr = to_int(12'(val));
      default: ;
    endcase
  endtask

  task automatic send_sample(input int t);
    @(negedge clk);
    smp_valid = 1'b1; smp_temp = 12'(t);
    @(negedge clk);
    smp_valid = 1'b0;
    e_flags = calc_flags(to_int(12'(t)), m_hi, m_lo, m_cr);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 flags at reset", dut_flags(), 0);
    chk("R1 pin at reset", int'(alarm_pull_low), 0);
    rst_n = 1'b1;
    alarm_en = 1'b1;
    @(negedge clk);
    chk("R1 pin after reset", int'(alarm_pull_low), 0);
    // R1: limits are zero: 0 -> crit only, 1 -> over+crit, -1 -> under
    send_sample(0);
    chk("R1 zero limits sample 0", dut_flags(), 4);
    send_sample(1);
    chk("R1 zero limits sample 1", dut_flags(), 5);
    send_sample(-1);
    chk("R1 zero limits sample -1", dut_flags(), 2);

    // R2/R3/R4 boundaries
    write_lim(2'b00, 400);
    write_lim(2'b01, -80);
    write_lim(2'b10, 1360);
    send_sample(400);  check_outputs("R2 equal to upper not over");
    send_sample(401);  check_outputs("R2 one above upper");
    send_sample(-80);  check_outputs("R3 equal to lower not under");
    send_sample(-81);  check_outputs("R3 one below lower");
    send_sample(1359); check_outputs("R4 one below crit");
    send_sample(1360); check_outputs("R4 equal to crit");
    chk("R4 crit flag at equal", int'(flag_crit), 1);

    // R9 signed extremes
    write_lim(2'b01, 5);
    send_sample(-1);
    chk("R9 -1 below lower 5", int'(flag_under_lo), 1);
    write_lim(2'b00, -2048);
    send_sample(2047);
    chk("R9 2047 above upper -2048", int'(flag_over_hi), 1);
    send_sample(-2048);
    chk("R9 -2048 not above upper -2048", int'(flag_over_hi), 0);
    check_outputs("R9 extremes");

    // R6 selector 11 changes nothing
    write_lim(2'b00, 100);
    write_lim(2'b01, -100);
    write_lim(2'b10, 200);
    write_lim(2'b11, 0);
    send_sample(150);
    chk("R6 sel 11 ignored", dut_flags(), 1);
    send_sample(-50);
    chk("R6 sel 11 ignored low", dut_flags(), 0);

    // R5 hold across limit writes and idle cycles
    send_sample(250);
    write_lim(2'b10, 1000);
    write_lim(2'b00, 1000);
    repeat (4) @(negedge clk);
    chk("R5 flags held after limit writes", dut_flags(), 5);
    // R6 new limits apply on next strobe
    send_sample(250);
    chk("R6 new limits used", dut_flags(), 0);

    // R7/R8 alarm gating
    send_sample(-500);
    chk("R7 pin with under flag", int'(alarm_pull_low), 1);
    alarm_en = 1'b0;
    #1;
    chk("R8 pin released when disabled", int'(alarm_pull_low), 0);
    alarm_en = 1'b1;
    #1;
    chk("R7 pin returns when enabled", int'(alarm_pull_low), 1);
    send_sample(0);
    chk("R7 pin idle with no flags", int'(alarm_pull_low), 0);
    e_flags = 0;

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 3));
      case (op)
        0: write_lim(2'($urandom_range(0, 3)), int'($urandom_range(0, 160)) - 80);
        1: begin
          if ($urandom_range(0, 9) == 0)
            send_sample(($urandom_range(0, 1) == 1) ? 2047 : -2048);
          else
            send_sample(int'($urandom_range(0, 160)) - 80);
          check_outputs("R2 R3 R4 random sample");
        end
        2: begin
          @(negedge clk);
          alarm_en = ~alarm_en;
          #1;
          check_outputs("R7 R8 random enable");
        end
        default: begin
          repeat (2) @(negedge clk);
          check_outputs("R5 random idle hold");
        end
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule